// File: doc/BRIEF.md
# Dual-Clock J-K Register Bank with Initialization and Pin Diagnostics

This block holds the registers of a programmable sequencer. It has a state register, whose contents feed back to the logic array, and an output register, whose contents go to the pins. Each register is built from J-K flip-flops. Per-bit J and K command vectors come from a logic array that is outside this block, and the bank applies them on the rising clock edge. A single configuration pin serves one of two roles, chosen by a parameter. It can be an asynchronous initialization input that loads a per-bit programmed pattern. It can instead be an active-low enable for the pin drivers.

The bank can be split into a lower and an upper half, each with its own clock. In that case each half runs as an independent machine. A synchronous power-up reset puts every bit at 1, whatever initialization pattern is programmed. After an initialization pulse, a half of the bank is locked until its clock has gone low. Only the rising edge after that low phase updates it, so a partial pulse cannot corrupt the first transition.

Three diagnostic flags let a tester see and set the registers through the bidirectional pins. One flag makes the pins show the state register. The other two release the pins so that external data can be loaded into the state register or into the output register.

Top module: `jk_regbank`

## Requirements
- R1: While `rst` is high on a rising edge of a half's clock, every state and output bit of that half becomes 1, independent of the programmed initialization pattern.
- R2: In initialization mode (`PIN_FN` = init), a high `init_oe` at once forces `state_q` to `INIT_STATE` and the output register to `INIT_OUT`, and they stay there while it is held, across clock edges.
- R3: After `init_oe` falls in initialization mode, a half ignores its first rising clock edge unless a falling edge of that clock has occurred since the release. The next rising edge after such a falling edge updates the half normally.
- R4: In output-enable mode, `init_oe` high turns `pad_en` off and has no effect on register contents. `init_oe` low turns the drivers on.
- R5: With `DUAL_CLK` = 1, `clk_a` updates bits 3:0 of both registers and `clk_b` updates bits 7:4. With `DUAL_CLK` = 0, `clk_a` updates all bits.
- R6: On a normal-mode rising edge each bit holds for J=0,K=0, becomes 1 for J=1,K=0, becomes 0 for J=0,K=1, and inverts for J=1,K=1.
- R7: With `diag_sread` high (and neither load flag), `pad_out` shows the state register, the state register keeps following J/K, and the output register keeps its value across clock edges.
- R8: With `diag_sjam` high, `pad_en` is 0 and a rising edge loads `pad_in` into the state register. The state J/K inputs are ignored and the output register is unchanged.
- R9: With `diag_ojam` high, `pad_en` is 0 and a rising edge loads `pad_in` into the output register. The output J/K inputs are ignored and the state register is unchanged.
- R10: When several diagnostic flags are high, output load wins over state load, and state load wins over state readout.
- R11: With no load flag, `pad_en` is 1 in initialization mode regardless of `init_oe`, and `pad_out` shows the output register unless readout is selected.

Parameters: `W` (bank width, default 8), `PIN_FN` (init or output enable), `DUAL_CLK` (default 1), `INIT_STATE`, `INIT_OUT`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Clock for the whole bank, or for the lower half in dual-clock mode |
| clk_b | input | 1 | Clock for the upper half in dual-clock mode; unused otherwise |
| rst | input | 1 | Synchronous active-high power-up preset to all ones |
| init_oe | input | 1 | Asynchronous initialization (active high) or pin enable (active low), per `PIN_FN` |
| diag_sread | input | 1 | Show the state register on the pins |
| diag_sjam | input | 1 | Load the pins into the state register |
| diag_ojam | input | 1 | Load the pins into the output register |
| st_j | input | W | J commands for the state register |
| st_k | input | W | K commands for the state register |
| out_j | input | W | J commands for the output register |
| out_k | input | W | K commands for the output register |
| pad_in | input | W | Data received from the pins |
| state_q | output | W | State register feedback |
| pad_out | output | W | Data driven to the pins |
| pad_en | output | W == 1 ? 1 : 1 | Pin driver enable |

## Verification
Register results appear on the first rising edge of the owning clock after the stimulus. The bench changes inputs on the falling edge of `clk_a` and samples 2 time units after the next rising edge, or after a manual `clk_b` pulse has completed. Initialization and driver-enable effects are combinational or asynchronous. They are sampled 1 time unit after the input changes, with no clock edge in between. The lockout case is checked on two edges in turn: the first rising edge after release must leave the pattern untouched, and the second must apply the toggle.

// File: rtl/jkb_pkg.sv
package jkb_pkg;

    // Diagnostic selection after priority resolution
    typedef enum logic [1:0] {
        DG_NORMAL = 2'd0,
        DG_SREAD  = 2'd1,
        DG_SJAM   = 2'd2,
        DG_OJAM   = 2'd3
    } diag_e;

    // Role of the shared configuration pin
    typedef enum logic {
        PIN_INIT = 1'b0,
        PIN_OE   = 1'b1
    } pinfn_e;

    // Pin path control
    typedef struct packed {
        logic drive;
        logic show_state;
    } padctl_t;

    // One J-K flip-flop next value
    function automatic logic jk_bit(input logic q, input logic j, input logic k);
        return (j & ~q) | (~k & q);
    endfunction

    // Output load > state load > state readout
    function automatic diag_e diag_pick(input logic oj, input logic sj, input logic sr);
        if (oj)      return DG_OJAM;
        else if (sj) return DG_SJAM;
        else if (sr) return DG_SREAD;
        else         return DG_NORMAL;
    endfunction

    function automatic padctl_t pad_ctl(input diag_e m, input logic oe_ok);
        padctl_t c;
        c.drive      = oe_ok && (m != DG_SJAM) && (m != DG_OJAM);
        c.show_state = (m == DG_SREAD);
        return c;
    endfunction

endpackage

// File: rtl/jkb_arm.sv
module jkb_arm (
    input  logic clk,
    input  logic init_hit,
    output logic armed
);
    // Cleared while initialization is held; set by the first falling clock
    // edge after release, so only the next full pulse updates the half.
    always_ff @(negedge clk or posedge init_hit) begin
        if (init_hit) armed <= 1'b0;
        else          armed <= 1'b1;
    end
endmodule

// File: rtl/jkb_slice.sv
module jkb_slice import jkb_pkg::*; #(
    parameter int          SW       = 4,
    parameter pinfn_e      PIN_FN   = PIN_INIT,
    parameter logic [SW-1:0] INIT_ST  = '0,
    parameter logic [SW-1:0] INIT_OUT = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          init_hit,
    input  diag_e         mode,
    input  logic [SW-1:0] st_j,
    input  logic [SW-1:0] st_k,
    input  logic [SW-1:0] out_j,
    input  logic [SW-1:0] out_k,
    input  logic [SW-1:0] pad_in,
    output logic [SW-1:0] st_q,
    output logic [SW-1:0] out_q
);
    logic [SW-1:0] st_jk, out_jk;
    logic [SW-1:0] st_nx, out_nx;
    logic          armed;

    for (genvar b = 0; b < SW; b++) begin : g_bit
        assign st_jk[b]  = jk_bit(st_q[b],  st_j[b],  st_k[b]);
        assign out_jk[b] = jk_bit(out_q[b], out_j[b], out_k[b]);
    end

    always_comb begin
        unique case (mode)
            DG_SJAM: begin st_nx = pad_in; out_nx = out_q;  end
            DG_OJAM: begin st_nx = st_q;   out_nx = pad_in; end
            DG_SREAD: begin st_nx = st_jk; out_nx = out_q;  end
            default: begin st_nx = st_jk;  out_nx = out_jk; end
        endcase
    end

    if (PIN_FN == PIN_INIT) begin : g_init
        jkb_arm u_arm (
            .clk      (clk),
            .init_hit (init_hit),
            .armed    (armed)
        );

        always_ff @(posedge clk or posedge init_hit) begin
            if (init_hit) begin
                st_q  <= INIT_ST;
                out_q <= INIT_OUT;
            end else if (rst) begin
                st_q  <= '1;
                out_q <= '1;
            end else if (armed) begin
                st_q  <= st_nx;
                out_q <= out_nx;
            end
        end
    end else begin : g_plain
        logic init_unused;
        assign init_unused = init_hit;
        assign armed       = 1'b1;

        always_ff @(posedge clk) begin
            if (rst) begin
                st_q  <= '1;
                out_q <= '1;
            end else begin
                st_q  <= st_nx;
                out_q <= out_nx;
            end
        end
    end

    // R1
    preset_all_ones_chk: assert property (@(posedge clk) disable iff (init_hit)
        rst |=> (st_q == '1 && out_q == '1));

    // R9
    out_load_chk: assert property (@(posedge clk) disable iff (rst || init_hit)
        (mode == DG_OJAM && armed) |=> (out_q == $past(pad_in) && $stable(st_q)));

    // R8
    st_load_chk: assert property (@(posedge clk) disable iff (rst || init_hit)
        (mode == DG_SJAM && armed) |=> (st_q == $past(pad_in) && $stable(out_q)));

    // R7
    readout_hold_chk: assert property (@(posedge clk) disable iff (rst || init_hit)
        (mode == DG_SREAD) |=> $stable(out_q));

endmodule

// File: rtl/jkb_pinmux.sv
module jkb_pinmux import jkb_pkg::*; #(
    parameter int W = 8
) (
    input  logic         diag_sread,
    input  logic         diag_sjam,
    input  logic         diag_ojam,
    input  logic         oe_ok,
    input  logic [W-1:0] st_q,
    input  logic [W-1:0] out_q,
    output diag_e        mode,
    output logic [W-1:0] pad_out,
    output logic         pad_en
);
    padctl_t ctl;

    always_comb begin
        mode    = diag_pick(diag_ojam, diag_sjam, diag_sread);
        ctl     = pad_ctl(mode, oe_ok);
        pad_en  = ctl.drive;
        pad_out = ctl.show_state ? st_q : out_q;
    end
endmodule

// File: rtl/jk_regbank.sv
module jk_regbank import jkb_pkg::*; #(
    parameter int           W          = 8,
    parameter pinfn_e       PIN_FN     = PIN_INIT,
    parameter bit           DUAL_CLK   = 1'b1,
    parameter logic [W-1:0] INIT_STATE = 8'hA5,
    parameter logic [W-1:0] INIT_OUT   = 8'h3C
) (
    input  logic         clk_a,
    input  logic         clk_b,
    input  logic         rst,
    input  logic         init_oe,
    input  logic         diag_sread,
    input  logic         diag_sjam,
    input  logic         diag_ojam,
    input  logic [W-1:0] st_j,
    input  logic [W-1:0] st_k,
    input  logic [W-1:0] out_j,
    input  logic [W-1:0] out_k,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] state_q,
    output logic [W-1:0] pad_out,
    output logic         pad_en
);
    localparam int NDOM = DUAL_CLK ? 2 : 1;
    localparam int SW   = W / NDOM;

    logic         init_hit;
    logic         oe_ok;
    diag_e        mode;
    logic [W-1:0] out_q;

    if (PIN_FN == PIN_INIT) begin : g_pin_init
        assign init_hit = init_oe;
        assign oe_ok    = 1'b1;
    end else begin : g_pin_oe
        assign init_hit = 1'b0;
        assign oe_ok    = ~init_oe;
    end

    if (!DUAL_CLK) begin : g_one_clk
        logic clk_b_unused;
        assign clk_b_unused = clk_b;
    end

    for (genvar d = 0; d < NDOM; d++) begin : g_dom
        logic dclk;
        if (d == 0) begin : g_ca
            assign dclk = clk_a;
        end else begin : g_cb
            assign dclk = clk_b;
        end

        jkb_slice #(
            .SW       (SW),
            .PIN_FN   (PIN_FN),
            .INIT_ST  (INIT_STATE[d*SW +: SW]),
            .INIT_OUT (INIT_OUT[d*SW +: SW])
        ) u_slice (
            .clk      (dclk),
            .rst      (rst),
            .init_hit (init_hit),
            .mode     (mode),
            .st_j     (st_j[d*SW +: SW]),
            .st_k     (st_k[d*SW +: SW]),
            .out_j    (out_j[d*SW +: SW]),
            .out_k    (out_k[d*SW +: SW]),
            .pad_in   (pad_in[d*SW +: SW]),
            .st_q     (state_q[d*SW +: SW]),
            .out_q    (out_q[d*SW +: SW])
        );
    end

    jkb_pinmux #(.W(W)) u_pin (
        .diag_sread (diag_sread),
        .diag_sjam  (diag_sjam),
        .diag_ojam  (diag_ojam),
        .oe_ok      (oe_ok),
        .st_q       (state_q),
        .out_q      (out_q),
        .mode       (mode),
        .pad_out    (pad_out),
        .pad_en     (pad_en)
    );

    // R8
    load_releases_pins_chk: assert property (@(posedge clk_a) disable iff (rst)
        (diag_ojam || diag_sjam) |-> !pad_en);

    if (PIN_FN == PIN_INIT) begin : g_init_chk
        // R2
        init_pattern_chk: assert property (@(posedge clk_a) disable iff (rst)
            init_oe |-> (state_q == INIT_STATE));
    end

endmodule

// File: tb/sim_jk_regbank.sv
module sim_jk_regbank;
    import jkb_pkg::*;

    localparam int CLK_P = 10;

    logic       clk_a = 1'b0;
    logic       clk_b = 1'b0;
    logic       rst = 1'b1;
    logic       init0 = 1'b0;
    logic       oe1 = 1'b0;
    logic       d_sr = 1'b0, d_sj = 1'b0, d_oj = 1'b0;
    logic [7:0] sj = '0, sk = '0, oj = '0, ok = '0, pin_in = '0;
    logic [7:0] st0, po0, st1, po1;
    logic       pe0, pe1;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #(CLK_P/2) clk_a = ~clk_a;

    jk_regbank #(.W(8), .PIN_FN(PIN_INIT), .DUAL_CLK(1'b1),
                 .INIT_STATE(8'hA5), .INIT_OUT(8'h3C)) u0 (
        .clk_a(clk_a), .clk_b(clk_b), .rst(rst), .init_oe(init0),
        .diag_sread(d_sr), .diag_sjam(d_sj), .diag_ojam(d_oj),
        .st_j(sj), .st_k(sk), .out_j(oj), .out_k(ok), .pad_in(pin_in),
        .state_q(st0), .pad_out(po0), .pad_en(pe0));

    jk_regbank #(.W(8), .PIN_FN(PIN_OE), .DUAL_CLK(1'b0),
                 .INIT_STATE(8'h00), .INIT_OUT(8'h00)) u1 (
        .clk_a(clk_a), .clk_b(clk_b), .rst(rst), .init_oe(oe1),
        .diag_sread(d_sr), .diag_sjam(d_sj), .diag_ojam(d_oj),
        .st_j(sj), .st_k(sk), .out_j(oj), .out_k(ok), .pad_in(pin_in),
        .state_q(st1), .pad_out(po1), .pad_en(pe1));

    // rows: {st_j, st_k, out_j, out_k, expected state, expected output}
    localparam logic [47:0] VEC [6] = '{
        {8'h00, 8'h0F, 8'h00, 8'hF0, 8'hF0, 8'h0F},
        {8'h0C, 8'h00, 8'h00, 8'h00, 8'hFC, 8'h0F},
        {8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h03, 8'hF0},
        {8'h50, 8'hA0, 8'h05, 8'h0A, 8'h53, 8'hF5},
        {8'h00, 8'h00, 8'h00, 8'h00, 8'h53, 8'hF5},
        {8'h81, 8'h81, 8'h3C, 8'hC3, 8'hD2, 8'h3C}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic pulse_b();
        #1 clk_b = 1'b1;
        #2 clk_b = 1'b0;
        #1;
    endtask

    task automatic quiet();
        sj = '0; sk = '0; oj = '0; ok = '0;
        d_sr = 1'b0; d_sj = 1'b0; d_oj = 1'b0;
    endtask

    task automatic wrap_up();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 100000);
        tests++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        wrap_up();
    end

    initial begin
        repeat (3) @(negedge clk_a);
        pulse_b();
        pulse_b();
        @(negedge clk_a);
        rst = 1'b0;
        #1;
        // R1: power-up preset ignores the programmed pattern
        chk("R1 u0 state", st0, 8'hFF);
        chk("R1 u0 pins", po0, 8'hFF);
        chk("R1 u1 state", st1, 8'hFF);
        chk("R1 u1 pins", po1, 8'hFF);

        // R6: J-K behaviour from the vector table, single clock (R5)
        foreach (VEC[i]) begin
            @(negedge clk_a);
            {sj, sk, oj, ok} = VEC[i][47:16];
            @(posedge clk_a);
            #2;
            chk("R6 state", st1, VEC[i][15:8]);
            chk("R6 R5 output", po1, VEC[i][7:0]);
        end
        @(negedge clk_a); quiet();

        // R4: output-enable role
        @(negedge clk_a);
        oe1 = 1'b1; sj = 8'h01;
        #1;
        chk("R4 drivers off", {7'd0, pe1}, 8'h00);
        @(posedge clk_a); #2;
        chk("R4 no init effect", st1, 8'hD3);
        @(negedge clk_a); oe1 = 1'b0; quiet();
        #1;
        chk("R4 drivers on", {7'd0, pe1}, 8'h01);

        // R2: asynchronous initialization pattern, held across clocks
        #1 init0 = 1'b1;
        #1;
        chk("R2 state pattern", st0, 8'hA5);
        chk("R2 output pattern", po0, 8'h3C);
        chk("R11 pins driven in init mode", {7'd0, pe0}, 8'h01);
        sj = 8'hFF; ok = 8'hFF;
        @(posedge clk_a); @(posedge clk_a); #2;
        pulse_b();
        chk("R2 clock blocked state", st0, 8'hA5);
        chk("R2 clock blocked output", po0, 8'h3C);

        // R3: lockout until a full pulse follows release
        @(negedge clk_a);
        quiet(); sj = 8'h0F; sk = 8'h0F;
        #2 init0 = 1'b0;
        @(posedge clk_a); #2;
        chk("R3 first edge ignored", st0, 8'hA5);
        @(posedge clk_a); #2;
        chk("R3 second edge toggles", st0, 8'hAA);
        @(negedge clk_a); quiet();
        pulse_b();
        chk("R3 upper half arming pulse", st0, 8'hAA);

        // R5: split clocking
        @(negedge clk_a);
        sk = 8'hFF; oj = 8'hFF;
        @(posedge clk_a); #2;
        chk("R5 clk_a lower state", st0, 8'hA0);
        chk("R5 clk_a lower output", po0, 8'h3F);
        pulse_b();
        chk("R5 clk_b upper state", st0, 8'h00);
        chk("R5 clk_b upper output", po0, 8'hFF);

        // R7: state readout
        @(negedge clk_a);
        quiet(); sj = 8'h0F; ok = 8'hFF; d_sr = 1'b1;
        #1;
        chk("R7 pins show state", po0, 8'h00);
        @(posedge clk_a); #2;
        pulse_b();
        chk("R7 state still follows J/K", po0, 8'h0F);
        @(negedge clk_a); quiet();
        #1;
        chk("R7 output register kept", po0, 8'hFF);

        // R8: state load
        @(negedge clk_a);
        d_sj = 1'b1; pin_in = 8'h5A; sk = 8'hFF; ok = 8'hFF;
        #1;
        chk("R8 pins released", {7'd0, pe0}, 8'h00);
        @(posedge clk_a); #2;
        pulse_b();
        chk("R8 state loaded", st0, 8'h5A);
        @(negedge clk_a); quiet();
        #1;
        chk("R8 output unchanged", po0, 8'hFF);

        // R9: output load
        @(negedge clk_a);
        d_oj = 1'b1; pin_in = 8'hC3; sk = 8'hFF; oj = 8'hFF;
        #1;
        chk("R9 pins released", {7'd0, pe0}, 8'h00);
        @(posedge clk_a); #2;
        pulse_b();
        @(negedge clk_a); quiet();
        #1;
        chk("R9 output loaded", po0, 8'hC3);
        chk("R9 state unchanged", st0, 8'h5A);

        // R10: priority among flags
        @(negedge clk_a);
        d_oj = 1'b1; d_sj = 1'b1; d_sr = 1'b1; pin_in = 8'h11;
        @(posedge clk_a); #2;
        pulse_b();
        @(negedge clk_a); quiet();
        #1;
        chk("R10 output load wins", po0, 8'h11);
        chk("R10 state untouched", st0, 8'h5A);
        @(negedge clk_a);
        d_sj = 1'b1; d_sr = 1'b1; pin_in = 8'h66;
        #1;
        chk("R10 state load beats readout", {7'd0, pe0}, 8'h00);
        @(posedge clk_a); #2;
        pulse_b();
        @(negedge clk_a); quiet();
        #1;
        chk("R10 state loaded", st0, 8'h66);
        chk("R10 R11 output shown", po0, 8'h11);

        wrap_up();
    end
endmodule